// File: doc/BRIEF.md
# Boot Region Remap Address Decoder

This block sits on a 32-bit unified memory-mapped bus. It decodes each request address to one of four targets: flash, RAM, the peripheral space, or a small system register block. It raises a one-hot select for the chosen target and gives the byte offset local to that target. The address range alone picks the target. An address that matches no region gets a one-cycle error response.

The region starting at address zero is an alias, and its target is chosen at run time. A remap bit in a system configuration register at 0x40010000 controls it. With the bit clear, which is the reset state, the zero region reaches flash. With it set, the zero region reaches RAM, so code can be fetched from RAM. Flash also stays reachable at its own base of 0x08000000 in both cases.

The block also holds a writable vector table base register at 0xE000ED08. The core uses its value to locate the vector table. Writing 0x20000000 to it moves the table to the RAM base.

Top module: `boot_remap_decoder`

## Requirements
- R1: After reset the remap bit reads 0, the vector base reads 0x00000000, err_o is 0 and rdata_o is 0.
- R2: A request in [0x08000000, 0x08000000 + 2^FLASH_AW) selects flash, with offset = address − 0x08000000.
- R3: A request in [0x20000000, 0x20000000 + 2^RAM_AW) selects RAM, with offset = address − 0x20000000.
- R4: With the remap bit at 0, a request in [0, 2^ALIAS_AW) selects flash, with offset = address.
- R5: With the remap bit at 1, a request in [0, 2^ALIAS_AW) selects RAM, with offset = address.
- R6: A write to the configuration word (address bits [31:2] equal to those of 0x40010000) loads write-data bit 0 into the remap bit. The new value is visible from the cycle after the write, and the write itself is decoded with the old value.
- R7: A request in [0x40000000, 0x60000000) selects the peripheral space, with offset = address − 0x40000000. The configuration word is the exception (see R8).
- R8: A request to the configuration word or to the vector base word (address bits [31:2] equal to those of 0xE000ED08) selects the system register block, with offset = address & 0xF.
- R9: A write to the vector base word stores write-data with bits [6:0] forced to 0. Those bits always read 0.
- R10: A request that hits no region selects no target, and err_o is 1 in the following cycle only.
- R11: At most one select is high at any time, and none is high while req_i is 0.
- R12: A read of a system register word returns its value on rdata_o in the following cycle. The configuration word reads as {31'b0, remap}. In every other cycle rdata_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Access request valid this cycle |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 32 | Byte address |
| wdata_i | input | 32 | Write data |
| sel_flash_o | output | 1 | Flash target select |
| sel_ram_o | output | 1 | RAM target select |
| sel_periph_o | output | 1 | Peripheral space select |
| sel_sys_o | output | 1 | System register block select |
| offset_o | output | 32 | Offset local to the selected target |
| err_o | output | 1 | Error response for an unmapped request, one cycle later |
| rdata_o | output | 32 | System register read data, one cycle later |
| remap_o | output | 1 | Current remap bit |
| vtor_o | output | 32 | Current vector table base |

## Verification
The bench builds the decoder with ALIAS_AW=12, FLASH_AW=16 and RAM_AW=14, so every region edge is a short, reachable address. These edges include the end of the zero alias at 0x1000, the first address past flash at 0x08010000 and the first address past RAM at 0x20004000, each of which must produce the error response. The peripheral window keeps its default 29-bit size, so the bench can probe its boundary at 0x60000000 as well as the configuration word inside it. A behavioural model follows the remap and vector base state. It confirms that a zero-address read returns flash data before the remap write and RAM data after it.

// File: rtl/boot_remap_pkg.sv
package boot_remap_pkg;

  localparam logic [31:0] DEF_FLASH_BASE  = 32'h0800_0000;
  localparam logic [31:0] DEF_RAM_BASE    = 32'h2000_0000;
  localparam logic [31:0] DEF_PERIPH_BASE = 32'h4000_0000;
  localparam logic [31:0] DEF_SYSCFG_ADDR = 32'h4001_0000;
  localparam logic [31:0] DEF_VTOR_ADDR   = 32'hE000_ED08;

  typedef enum logic [2:0] {
    TGT_NONE   = 3'd0,
    TGT_FLASH  = 3'd1,
    TGT_RAM    = 3'd2,
    TGT_PERIPH = 3'd3,
    TGT_SYS    = 3'd4
  } tgt_e;

  typedef struct packed {
    logic flash;
    logic ram;
    logic periph;
    logic sys;
  } sel_t;

endpackage

// File: rtl/region_match.sv
module region_match #(
  parameter logic [31:0] BASE = 32'h0,
  parameter int unsigned AW   = 16
) (
  input  logic [31:0] addr_i,
  output logic        hit_o,
  output logic [31:0] offset_o
);
  localparam logic [31:0] MASK = (32'h1 << AW) - 32'h1;

  assign hit_o    = (addr_i[31:AW] == BASE[31:AW]);
  assign offset_o = addr_i & MASK;
endmodule

// File: rtl/boot_sysregs.sv
module boot_sysregs #(
  parameter logic [31:0] SYSCFG_ADDR = boot_remap_pkg::DEF_SYSCFG_ADDR,
  parameter logic [31:0] VTOR_ADDR   = boot_remap_pkg::DEF_VTOR_ADDR,
  parameter int unsigned VTOR_ALIGN  = 7
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        req_i,
  input  logic        we_i,
  input  logic [31:0] addr_i,
  input  logic [31:0] wdata_i,
  output logic        hit_o,
  output logic        remap_o,
  output logic [31:0] vtor_o,
  output logic [31:0] rdata_o
);
  localparam logic [31:0] VTOR_MASK = ~((32'h1 << VTOR_ALIGN) - 32'h1);

  logic        cfg_hit, vtor_hit;
  logic        remap_q;
  logic [31:0] vtor_q, rdata_q;
  logic        wr_cfg, wr_vtor, rd_cfg, rd_vtor;

  assign cfg_hit  = (addr_i[31:2] == SYSCFG_ADDR[31:2]);
  assign vtor_hit = (addr_i[31:2] == VTOR_ADDR[31:2]);
  assign hit_o    = cfg_hit | vtor_hit;

  assign wr_cfg  = req_i &  we_i & cfg_hit;
  assign wr_vtor = req_i &  we_i & vtor_hit;
  assign rd_cfg  = req_i & ~we_i & cfg_hit;
  assign rd_vtor = req_i & ~we_i & vtor_hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      remap_q <= 1'b0;
      vtor_q  <= '0;
      rdata_q <= '0;
    end else begin
      if (wr_cfg)  remap_q <= wdata_i[0];
      if (wr_vtor) vtor_q  <= wdata_i & VTOR_MASK;
      if (rd_cfg)       rdata_q <= {31'b0, remap_q};
      else if (rd_vtor) rdata_q <= vtor_q;
      else              rdata_q <= '0;
    end
  end

  assign remap_o = remap_q;
  assign vtor_o  = vtor_q;
  assign rdata_o = rdata_q;

  // R6: remap follows the written bit one cycle later
  a_r6_remap_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_cfg |=> (remap_o == $past(wdata_i[0])));
  a_r6_remap_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_cfg |=> $stable(remap_o));
  // R9: low bits of a vector base write are dropped
  a_r9_vtor_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_vtor |=> (vtor_o == ($past(wdata_i) & VTOR_MASK)));
  // R12: read data is a one-cycle response
  a_r12_rdata_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_cfg || rd_vtor) |=> (rdata_o == 32'h0));
endmodule

// File: rtl/boot_decode_core.sv
module boot_decode_core
  import boot_remap_pkg::*;
(
  input  logic        req_i,
  input  logic        remap_i,
  input  logic [31:0] addr_i,
  input  logic        alias_hit_i,
  input  logic        flash_hit_i,
  input  logic        ram_hit_i,
  input  logic        periph_hit_i,
  input  logic        sys_hit_i,
  input  logic [31:0] alias_off_i,
  input  logic [31:0] flash_off_i,
  input  logic [31:0] ram_off_i,
  input  logic [31:0] periph_off_i,
  output sel_t        sel_o,
  output logic [31:0] offset_o,
  output logic        miss_o
);
  tgt_e tgt;

  // system words win over the peripheral window they sit in
  always_comb begin
    tgt      = TGT_NONE;
    offset_o = '0;
    if (req_i) begin
      if (sys_hit_i) begin
        tgt      = TGT_SYS;
        offset_o = {28'b0, addr_i[3:0]};
      end else if (alias_hit_i) begin
        tgt      = remap_i ? TGT_RAM : TGT_FLASH;
        offset_o = alias_off_i;
      end else if (flash_hit_i) begin
        tgt      = TGT_FLASH;
        offset_o = flash_off_i;
      end else if (ram_hit_i) begin
        tgt      = TGT_RAM;
        offset_o = ram_off_i;
      end else if (periph_hit_i) begin
        tgt      = TGT_PERIPH;
        offset_o = periph_off_i;
      end
    end
  end

  always_comb begin
    sel_o        = '0;
    sel_o.flash  = (tgt == TGT_FLASH);
    sel_o.ram    = (tgt == TGT_RAM);
    sel_o.periph = (tgt == TGT_PERIPH);
    sel_o.sys    = (tgt == TGT_SYS);
  end

  assign miss_o = req_i & (tgt == TGT_NONE);
endmodule

// File: rtl/boot_remap_decoder.sv
module boot_remap_decoder
  import boot_remap_pkg::*;
#(
  parameter logic [31:0] FLASH_BASE  = DEF_FLASH_BASE,
  parameter logic [31:0] RAM_BASE    = DEF_RAM_BASE,
  parameter logic [31:0] PERIPH_BASE = DEF_PERIPH_BASE,
  parameter logic [31:0] SYSCFG_ADDR = DEF_SYSCFG_ADDR,
  parameter logic [31:0] VTOR_ADDR   = DEF_VTOR_ADDR,
  parameter int unsigned ALIAS_AW    = 16,
  parameter int unsigned FLASH_AW    = 20,
  parameter int unsigned RAM_AW      = 17,
  parameter int unsigned PERIPH_AW   = 29,
  parameter int unsigned VTOR_ALIGN  = 7
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        req_i,
  input  logic        we_i,
  input  logic [31:0] addr_i,
  input  logic [31:0] wdata_i,
  output logic        sel_flash_o,
  output logic        sel_ram_o,
  output logic        sel_periph_o,
  output logic        sel_sys_o,
  output logic [31:0] offset_o,
  output logic        err_o,
  output logic [31:0] rdata_o,
  output logic        remap_o,
  output logic [31:0] vtor_o
);
  localparam logic [31:0] ALIAS_BASE = 32'h0;

  logic        alias_hit, flash_hit, ram_hit, periph_hit, sys_hit;
  logic [31:0] alias_off, flash_off, ram_off, periph_off;
  logic        miss, err_q;
  sel_t        sel;

  region_match #(.BASE(ALIAS_BASE),  .AW(ALIAS_AW))  u_alias (
    .addr_i(addr_i), .hit_o(alias_hit),  .offset_o(alias_off));
  region_match #(.BASE(FLASH_BASE),  .AW(FLASH_AW))  u_flash (
    .addr_i(addr_i), .hit_o(flash_hit),  .offset_o(flash_off));
  region_match #(.BASE(RAM_BASE),    .AW(RAM_AW))    u_ram (
    .addr_i(addr_i), .hit_o(ram_hit),    .offset_o(ram_off));
  region_match #(.BASE(PERIPH_BASE), .AW(PERIPH_AW)) u_periph (
    .addr_i(addr_i), .hit_o(periph_hit), .offset_o(periph_off));

  boot_sysregs #(
    .SYSCFG_ADDR(SYSCFG_ADDR),
    .VTOR_ADDR  (VTOR_ADDR),
    .VTOR_ALIGN (VTOR_ALIGN)
  ) u_sysregs (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .req_i  (req_i),
    .we_i   (we_i),
    .addr_i (addr_i),
    .wdata_i(wdata_i),
    .hit_o  (sys_hit),
    .remap_o(remap_o),
    .vtor_o (vtor_o),
    .rdata_o(rdata_o)
  );

  boot_decode_core u_core (
    .req_i       (req_i),
    .remap_i     (remap_o),
    .addr_i      (addr_i),
    .alias_hit_i (alias_hit),
    .flash_hit_i (flash_hit),
    .ram_hit_i   (ram_hit),
    .periph_hit_i(periph_hit),
    .sys_hit_i   (sys_hit),
    .alias_off_i (alias_off),
    .flash_off_i (flash_off),
    .ram_off_i   (ram_off),
    .periph_off_i(periph_off),
    .sel_o       (sel),
    .offset_o    (offset_o),
    .miss_o      (miss)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) err_q <= 1'b0;
    else         err_q <= miss;
  end

  assign sel_flash_o  = sel.flash;
  assign sel_ram_o    = sel.ram;
  assign sel_periph_o = sel.periph;
  assign sel_sys_o    = sel.sys;
  assign err_o        = err_q;

  // R11: one target at most, none without a request
  a_r11_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({sel_flash_o, sel_ram_o, sel_periph_o, sel_sys_o}));
  a_r11_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |-> ({sel_flash_o, sel_ram_o, sel_periph_o, sel_sys_o} == 4'b0));
  // R4 / R5: zero alias follows the remap bit
  a_r4_alias_flash: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && alias_hit && !sys_hit && !remap_o) |-> sel_flash_o);
  a_r5_alias_ram: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && alias_hit && !sys_hit && remap_o) |-> sel_ram_o);
  // R10: error only after an unselected request
  a_r10_err_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !(sel_flash_o || sel_ram_o || sel_periph_o || sel_sys_o)) |=> err_o);
  a_r10_err_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!req_i || sel_flash_o || sel_ram_o || sel_periph_o || sel_sys_o) |=> !err_o);
endmodule

// File: tb/boot_remap_decoder_bench.sv
`timescale 1ns/1ps
module boot_remap_decoder_bench;
  localparam int ALIAS_AW  = 12;
  localparam int FLASH_AW  = 16;
  localparam int RAM_AW    = 14;
  localparam int PERIPH_AW = 29;
  localparam longint unsigned FB  = 64'h0800_0000;
  localparam longint unsigned RB  = 64'h2000_0000;
  localparam longint unsigned PB  = 64'h4000_0000;
  localparam longint unsigned CFG = 64'h4001_0000;
  localparam longint unsigned VT  = 64'hE000_ED08;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [31:0] addr = '0, wdata = '0;
  logic        s_fl, s_ram, s_per, s_sys, err, remap;
  logic [31:0] offset, rdata, vtor;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  bit          m_remap = 0;
  logic [31:0] m_vtor = '0;
  bit          m_err = 0;
  logic [31:0] m_rdata = '0;

  always #2.5 clk = ~clk;

  boot_remap_decoder #(
    .ALIAS_AW(ALIAS_AW), .FLASH_AW(FLASH_AW), .RAM_AW(RAM_AW), .PERIPH_AW(PERIPH_AW)
  ) u_boot_remap_decoder (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr), .wdata_i(wdata),
    .sel_flash_o(s_fl), .sel_ram_o(s_ram), .sel_periph_o(s_per), .sel_sys_o(s_sys),
    .offset_o(offset), .err_o(err), .rdata_o(rdata), .remap_o(remap), .vtor_o(vtor)
  );

  function automatic logic [31:0] flash_word(logic [31:0] o);
    return 32'hF1A5_0000 ^ o;
  endfunction
  function automatic logic [31:0] ram_word(logic [31:0] o);
    return 32'h5A5A_0000 ^ o;
  endfunction

  task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  // 0 none, 1 flash, 2 ram, 3 periph, 4 sys
  task automatic model_decode(input longint unsigned a, output int t, output longint unsigned o);
    t = 0; o = 0;
    if ((a >> 2) == (CFG >> 2) || (a >> 2) == (VT >> 2)) begin t = 4; o = a & 15; end
    else if (a < (64'd1 << ALIAS_AW)) begin t = m_remap ? 2 : 1; o = a; end
    else if (a >= FB && a < FB + (64'd1 << FLASH_AW)) begin t = 1; o = a - FB; end
    else if (a >= RB && a < RB + (64'd1 << RAM_AW)) begin t = 2; o = a - RB; end
    else if (a >= PB && a < PB + (64'd1 << PERIPH_AW)) begin t = 3; o = a - PB; end
  endtask

  task automatic cyc(bit rq, bit w, logic [31:0] a, logic [31:0] d, string tag);
    int t;
    longint unsigned o;
    logic [31:0] data;
    @(negedge clk);
    chk({tag, " R10 err_o"}, {31'b0, err}, {31'b0, m_err});
    chk({tag, " R12 rdata_o"}, rdata, m_rdata);
    chk({tag, " R6 remap_o"}, {31'b0, remap}, {31'b0, m_remap});
    chk({tag, " R9 vtor_o"}, vtor, m_vtor);
    req = rq; we = w; addr = a; wdata = d;
    #1;
    model_decode(a, t, o);
    if (!rq) t = 0;
    chk({tag, " R11 selects"}, {28'b0, s_fl, s_ram, s_per, s_sys},
        {28'b0, t == 1, t == 2, t == 3, t == 4});
    if (t != 0) chk({tag, " R2/R3/R7/R8 offset"}, offset, o[31:0]);
    if (rq && !w && (t == 1 || t == 2)) begin
      data = s_fl ? flash_word(offset) : s_ram ? ram_word(offset) : 32'hDEAD_BEEF;
      chk({tag, " R4/R5 read data"}, data, (t == 1) ? flash_word(o[31:0]) : ram_word(o[31:0]));
    end
    m_err   = rq && (t == 0);
    m_rdata = '0;
    if (rq && !w && t == 4)
      m_rdata = ((longint'(a) >> 2) == (CFG >> 2)) ? {31'b0, m_remap} : m_vtor;
    if (rq && w && t == 4) begin
      if ((longint'(a) >> 2) == (CFG >> 2)) m_remap = d[0];
      else m_vtor = d & 32'hFFFF_FF80;
    end
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 remap after reset", {31'b0, remap}, 32'h0);
    chk("R1 vtor after reset", vtor, 32'h0);
    chk("R1 err after reset", {31'b0, err}, 32'h0);
    chk("R1 rdata after reset", rdata, 32'h0);

    cyc(0, 0, 32'h0, 0, "R11 idle");
    cyc(1, 0, 32'h0000_0000, 0, "R4 zero before remap");
    cyc(1, 0, 32'h0000_0FFC, 0, "R4 alias top");
    cyc(1, 0, 32'h0000_1000, 0, "R10 past alias");
    cyc(1, 0, 32'h0800_0010, 0, "R2 flash");
    cyc(1, 0, 32'h0800_FFFC, 0, "R2 flash top");
    cyc(1, 0, 32'h0801_0000, 0, "R10 past flash");
    cyc(1, 0, 32'h2000_0020, 0, "R3 ram");
    cyc(1, 0, 32'h2000_3FFC, 0, "R3 ram top");
    cyc(1, 0, 32'h2000_4000, 0, "R10 past ram");
    cyc(1, 0, 32'h4000_0004, 0, "R7 periph");
    cyc(1, 0, 32'h4001_0004, 0, "R7 next to cfg");
    cyc(1, 0, 32'h5FFF_FFFC, 0, "R7 periph top");
    cyc(1, 0, 32'h6000_0000, 0, "R10 past periph");
    cyc(1, 0, 32'h4001_0000, 0, "R12 read cfg");
    cyc(1, 1, 32'h4001_0000, 32'h1, "R6 set remap");
    cyc(1, 0, 32'h0000_0000, 0, "R5 zero after remap");
    cyc(1, 0, 32'h0800_0000, 0, "R2 flash kept");
    cyc(1, 0, 32'h4001_0000, 0, "R12 read cfg set");
    cyc(1, 1, 32'hE000_ED08, 32'h2000_00FF, "R9 vtor low bits");
    cyc(1, 0, 32'hE000_ED08, 0, "R9 read vtor");
    cyc(1, 1, 32'hE000_ED08, 32'h2000_0000, "R8 vtor to ram");
    cyc(1, 0, 32'hE000_ED0A, 0, "R8 vtor byte");
    cyc(1, 1, 32'h4001_0000, 32'hFFFF_FFFE, "R6 clear remap");
    cyc(1, 0, 32'h0000_0000, 0, "R4 zero flash again");
    cyc(1, 1, 32'h4001_0000, 32'h1, "R6 set again");
    cyc(1, 0, 32'h0000_0004, 0, "R5 ram alias");
    cyc(0, 0, 32'h0000_0000, 0, "R11 idle zero");
    cyc(0, 0, 32'h0000_0000, 0, "R10 err drop");

    for (int i = 0; i < 400; i++) begin
      int k;
      logic [31:0] a;
      logic [31:0] r;
      bit w;
      k = $urandom_range(0, 7);
      r = $urandom;
      w = 0;
      case (k)
        0: a = r & 32'h0000_1FFC;
        1: a = 32'h0800_0000 | (r & 32'h0001_FFFC);
        2: a = 32'h2000_0000 | (r & 32'h0000_7FFC);
        3: a = 32'h4000_0000 | (r & 32'h3FFF_FFFC);
        4: begin a = 32'h4001_0000; w = r[7]; end
        5: begin a = 32'hE000_ED08; w = r[6]; end
        6: a = r;
        default: a = 32'h0;
      endcase
      cyc(r[31] | r[30], w, a, $urandom, "R11 random");
    end
    cyc(0, 0, 32'h0, 0, "R11 tail");

    done = 1;
    finish_run();
  end
endmodule